// File: doc/BRIEF.md
# Nibble-serial three-share cipher round sequencer

This block is the control state machine for a masked, nibble-serial block cipher datapath that carries its state as three shares. Once started, it steps through a fixed number of sub-steps for each nibble of the state. Each sub-step is one use of a shared quadratic S-box stage on one share. On the last nibble of every round, the final sub-step is replaced by a permutation-layer cycle.

The block counts completed rounds. When the round limit is reached it opens the output gate for one cycle per nibble, so the result leaves nibble by nibble. It then raises `done` and keeps it high until a new start.

The datapath registers, the S-box functions and the key schedule lie outside the block. They act on its strobes: one one-hot strobe per sub-step, a permutation strobe, a nibble-advance strobe and the output gate. With the default parameters (6 sub-steps, 16 nibbles, 31 rounds), a round lasts 96 cycles. The first cycle of the output phase, which is also the first cycle with `done` high, comes 2976 clock edges after the edge that samples `start`.

Top module: `mask_round_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its initial state. All strobes, `out_en` and `done` are low, and `nib_idx` and `round_cnt` are zero. Without a start it stays there.
- R2: A `start` high at an edge in the initial state begins a run. In the next cycle `sbox_stb` is 1 (bit 0 set), and `nib_idx` and `round_cnt` are 0.
- R3: Within a nibble, bits 0 to SUBSTEPS-1 of `sbox_stb` are set one at a time, in ascending order, for one cycle each. `nib_adv` is high in the final slot, and `nib_idx` increments after it and wraps from NIBBLES-1 to 0.
- R4: On nibble NIBBLES-1 of every round, the final sub-step slot carries `perm_stb` = 1 and `sbox_stb` = 0, with `nib_adv` high. At most one of these strobes is ever high.
- R5: A round lasts SUBSTEPS×NIBBLES cycles. `round_cnt` increments in the cycle after each permutation cycle and changes at no other time, except when a start clears it.
- R6: After ROUNDS rounds, `done` rises exactly ROUNDS×SUBSTEPS×NIBBLES edges after the start edge. This is in the cycle after the last permutation cycle.
- R7: `out_en` is high for exactly NIBBLES consecutive cycles starting in that cycle, with `nib_idx` counting 0 to NIBBLES-1 and `round_cnt` equal to ROUNDS. It is never high otherwise.
- R8: After the output phase, `done` stays high, with `out_en` and all strobes low and `nib_idx` 0, until a start. That start clears `done` and repeats the R2 to R7 timeline.
- R9: `start` has no effect during a run or the output phase. The strobe and counter sequence and the cycle at which `done` rises are unchanged. This includes a start held high for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle or done |
| sbox_stb | output | SUBSTEPS | One-hot sub-step strobe for the shared S-box stage |
| perm_stb | output | 1 | Permutation-layer cycle |
| nib_adv | output | 1 | Last cycle of a nibble; datapath shifts to the next nibble |
| nib_idx | output | clog2(NIBBLES) | Current nibble index |
| round_cnt | output | clog2(ROUNDS+1) | Completed rounds |
| out_en | output | 1 | Output gate open: result nibble is valid |
| done | output | 1 | Result produced; held until next start |

## Verification
Two events coincide in the final permutation cycle: the permutation takes the place of the last sub-step, and the round counter reaches its limit. In that one cycle the block has to choose the output phase instead of another round. The bench runs whole messages of about 3000 cycles and compares every output in every cycle against a position-derived expectation (round, nibble and slot from the cycle index). This pins down that cycle and the first `done` cycle exactly.

A second coincidence is a start pulse arriving while the sequencer is busy. The bench provokes it with pulses inside a round and a start held over several edges. It judges the case by requiring the full per-cycle sequence to stay unchanged.

// File: rtl/rcc_pkg.sv
// Shared types for the round sequencer.
// Assumes: encodings are internal only; no neighbour decodes them.
package rcc_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_SBOX,
        ST_PERM,
        ST_FIN,
        ST_DONE
    } rcc_state_e;
endpackage

// File: rtl/rcc_wrap_ctr.sv
// Wrapping up-counter with synchronous clear and a terminal-value flag.
// Assumes: MAX fits in W bits; clear has priority over increment.
module rcc_wrap_ctr #(
    parameter int W   = 4,
    parameter int MAX = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    // terminal value reached
    assign at_max = (cnt == W'(MAX));

    // count register: clear, else step and wrap at MAX
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (inc)    cnt <= at_max ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/rcc_strobe_dec.sv
// Index-to-one-hot decoder for the sub-step strobes.
// Assumes: idx below N whenever en is high; output all-zero when en is low.
module rcc_strobe_dec #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    // one comparator per strobe bit
    for (genvar k = 0; k < N; k++) begin : g_bit
        assign onehot[k] = en && (idx == W'(k));
    end
endmodule

// File: rtl/mask_round_ctl.sv
// Round sequencer for a nibble-serial three-share cipher datapath.
// Steps SUBSTEPS sub-steps per nibble over NIBBLES nibbles, swaps the final
// sub-step of each round's last nibble for a permutation cycle, counts rounds,
// opens the output gate for NIBBLES cycles after ROUNDS rounds and holds done.
// Assumes: SUBSTEPS >= 2, NIBBLES >= 2; start is ignored while running.
module mask_round_ctl
    import rcc_pkg::*;
#(
    parameter  int SUBSTEPS = 6,
    parameter  int NIBBLES  = 16,
    parameter  int ROUNDS   = 31,
    localparam int SUB_W    = $clog2(SUBSTEPS),
    localparam int NIB_W    = $clog2(NIBBLES),
    localparam int RND_W    = $clog2(ROUNDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic [SUBSTEPS-1:0] sbox_stb,
    output logic                perm_stb,
    output logic                nib_adv,
    output logic [NIB_W-1:0]    nib_idx,
    output logic [RND_W-1:0]    round_cnt,
    output logic                out_en,
    output logic                done
);
    rcc_state_e        state_q, state_d;
    logic [SUB_W-1:0]  sub_idx;
    logic              sub_last, nib_last, rnd_max_unused;
    logic              in_sbox, in_perm, in_fin;
    logic              take_start, to_perm, last_round;

    // state decodes
    assign in_sbox    = (state_q == ST_SBOX);
    assign in_perm    = (state_q == ST_PERM);
    assign in_fin     = (state_q == ST_FIN);
    assign take_start = start && (state_q == ST_INIT || state_q == ST_DONE);
    assign to_perm    = in_sbox && nib_last && (sub_idx == SUB_W'(SUBSTEPS - 2));
    assign last_round = (round_cnt == RND_W'(ROUNDS - 1));

    // sub-step slot within a nibble
    rcc_wrap_ctr #(.W(SUB_W), .MAX(SUBSTEPS - 1)) u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start || to_perm),
        .inc    (in_sbox),
        .cnt    (sub_idx),
        .at_max (sub_last)
    );

    // nibble position, also used as output-phase index
    rcc_wrap_ctr #(.W(NIB_W), .MAX(NIBBLES - 1)) u_nib (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start),
        .inc    ((in_sbox && sub_last) || in_perm || in_fin),
        .cnt    (nib_idx),
        .at_max (nib_last)
    );

    // completed-round count
    rcc_wrap_ctr #(.W(RND_W), .MAX(ROUNDS)) u_rnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start),
        .inc    (in_perm),
        .cnt    (round_cnt),
        .at_max (rnd_max_unused)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (start)   state_d = ST_SBOX;
            ST_SBOX: if (to_perm) state_d = ST_PERM;
            ST_PERM:              state_d = last_round ? ST_FIN : ST_SBOX;
            ST_FIN:  if (nib_last) state_d = ST_DONE;
            ST_DONE: if (start)   state_d = ST_SBOX;
            default:              state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // sub-step strobes
    rcc_strobe_dec #(.N(SUBSTEPS), .W(SUB_W)) u_dec (
        .en     (in_sbox),
        .idx    (sub_idx),
        .onehot (sbox_stb)
    );

    // remaining control outputs
    assign perm_stb = in_perm;
    assign nib_adv  = (in_sbox && sub_last) || in_perm;
    assign out_en   = in_fin;
    assign done     = in_fin || (state_q == ST_DONE);
endmodule

// File: rtl/mask_round_ctl_chk.sv
// Property checker for mask_round_ctl, attached by bind below.
// Assumes: same parameters as the bound instance.
module mask_round_ctl_chk #(
    parameter  int SUBSTEPS = 6,
    parameter  int NIBBLES  = 16,
    parameter  int ROUNDS   = 31,
    localparam int NIB_W    = $clog2(NIBBLES),
    localparam int RND_W    = $clog2(ROUNDS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [SUBSTEPS-1:0] sbox_stb,
    input logic                perm_stb,
    input logic                nib_adv,
    input logic [NIB_W-1:0]    nib_idx,
    input logic [RND_W-1:0]    round_cnt,
    input logic                out_en,
    input logic                done
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sbox_stb, perm_stb}));

    // R4
    perm_last_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_stb |-> (nib_idx == NIB_W'(NIBBLES - 1)) && nib_adv);

    // R3
    sub_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sbox_stb[0] |=> sbox_stb[1]);

    // R5
    round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perm_stb && !start) |=> $stable(round_cnt));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(perm_stb) && out_en);

    // R7
    gate_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (round_cnt == RND_W'(ROUNDS)) && done);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(done) && $past(rst_n)) |-> $past(start));
endmodule

bind mask_round_ctl mask_round_ctl_chk #(
    .SUBSTEPS (SUBSTEPS),
    .NIBBLES  (NIBBLES),
    .ROUNDS   (ROUNDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sbox_stb  (sbox_stb),
    .perm_stb  (perm_stb),
    .nib_adv   (nib_adv),
    .nib_idx   (nib_idx),
    .round_cnt (round_cnt),
    .out_en    (out_en),
    .done      (done)
);

// File: tb/sim_mask_round_ctl.sv
`timescale 1ns/1ps
// Bench: full per-cycle sweep of whole messages against a position model.
module sim_mask_round_ctl;
    localparam int SUBS = 6, NIBS = 16, RNDS = 31;
    localparam int RLEN = SUBS * NIBS;
    localparam int TFIN = RNDS * RLEN;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [5:0]  sbox_stb;
    logic        perm_stb, nib_adv, out_en, done;
    logic [3:0]  nib_idx;
    logic [4:0]  round_cnt;
    int          n_chk = 0, n_bad = 0;
    bit          ended = 1'b0;

    always #2.5 clk = ~clk;

    mask_round_ctl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sbox_stb(sbox_stb),
        .perm_stb(perm_stb), .nib_adv(nib_adv), .nib_idx(nib_idx),
        .round_cnt(round_cnt), .out_en(out_en), .done(done)
    );

    function automatic logic [18:0] actual();
        return {sbox_stb, perm_stb, nib_adv, nib_idx, round_cnt, out_en, done};
    endfunction

    // expected outputs t cycles after the start edge
    function automatic logic [18:0] expv(int t);
        int r, q, n, s;
        logic pm;
        if (t < TFIN) begin
            r = t / RLEN; q = t % RLEN; n = q / SUBS; s = q % SUBS;
            pm = (n == NIBS - 1) && (s == SUBS - 1);
            return {pm ? 6'd0 : 6'(1 << s), pm, (s == SUBS - 1), 4'(n), 5'(r), 1'b0, 1'b0};
        end else if (t < TFIN + NIBS)
            return {6'd0, 1'b0, 1'b0, 4'(t - TFIN), 5'(RNDS), 1'b1, 1'b1};
        else
            return {6'd0, 1'b0, 1'b0, 4'd0, 5'(RNDS), 1'b0, 1'b1};
    endfunction

    task automatic check(string req, logic [18:0] a, logic [18:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    // one message: start held `hold` edges, extra pulses at p1/p2 edges
    task automatic run_msg(int hold, int p1, int p2, int len);
        string req;
        start = 1'b1;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t == 0) req = "R2";
            else if ((t > p1 && t <= p1 + 8) || (t > p2 && t <= p2 + 8) || t < hold + 8) req = "R9";
            else if (t < TFIN && (t % RLEN) == RLEN - 1) req = "R4";
            else if (t < TFIN && (t % RLEN) == 0) req = "R5";
            else if (t < TFIN) req = "R3";
            else if (t == TFIN) req = "R6";
            else if (t < TFIN + NIBS) req = "R7";
            else req = "R8";
            check(req, actual(), expv(t));
            start = ((t + 1) < hold) || (t + 1 == p1) || (t + 1 == p2);
        end
        start = 1'b0;
    endtask

    task automatic check_idle(string req, int n, logic dn);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, actual(), {6'd0, 1'b0, 1'b0, 4'd0, dn ? 5'(RNDS) : 5'd0, 1'b0, dn});
        end
    endtask

    initial begin
        // R1: reset state, then idle without start
        repeat (2) @(negedge clk);
        check("R1", actual(), 19'd0);
        rst_n = 1'b1;
        check_idle("R1", 4, 1'b0);
        // R2..R9: message from idle with pulses mid-round and in output phase
        run_msg(1, 500, TFIN + 3, TFIN + NIBS + 10);
        // R8: done held without start
        check_idle("R8", 20, 1'b1);
        // R8 R9: restart from done, start held several edges
        run_msg(3, 1234, TFIN - 1, TFIN + NIBS + 4);
        // R1: reset mid-run
        run_msg(1, -5, -5, 200);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", actual(), 19'd0);
        rst_n = 1'b1;
        check_idle("R1", 5, 1'b0);
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule